// File: doc/BRIEF.md
# Digit-Parallel Binary to Decimal Converter

This block turns an unsigned binary value into eight packed 4-bit decimal digits, for use ahead of a decimal display. The shift-and-correct method produces one binary bit per cycle. This block instead produces one whole decimal digit per cycle. It works from the ten-millions place downward. On each step it tests the running remainder against all nine multiples of that place's power of ten at the same time. It keeps the largest multiple that still fits, and that multiple's index is the digit. It then subtracts the multiple from the remainder.

A one-cycle start pulse captures the input. Seven steps follow. After the last step, a one-cycle done pulse marks the results as valid. The units digit is whatever remains once the tens place has been resolved. Each step only has to cover a remainder three or four bits narrower than the step before it, so the comparators for the lower places are smaller. An input too large for eight digits raises an overflow flag and shows nines in every digit.

Top module: `bcd_converter`

## Requirements
- R1: After reset, `bcdDigits` is all zeros, and `overflow` and `done` are low.
- R2: When the block is idle, a high `start` at a rising edge captures `binIn`. `done` is then high for exactly one cycle, starting at the seventh rising edge after the capturing edge. It is low at every other time.
- R3: For inputs below 100,000,000, the nibble at bits [4k+3:4k] of `bcdDigits` equals (value / 10^k) mod 10. Here k = 0 is the units digit and k = 7 is the ten-millions digit. This includes 0, 99,999,999 and every power of ten.
- R4: A `start` pulse during the seven conversion cycles is ignored. The result and the timing of `done` follow the value that was accepted earlier, and no extra `done` pulse appears.
- R5: An input of 100,000,000 or more, up to 2^27-1, gives `overflow` = 1 and a 9 in every digit (0x99999999). An in-range input gives `overflow` = 0.
- R6: After `done`, `bcdDigits` and `overflow` keep their values until the next accepted `start`, whatever `binIn` does.
- R7: A `start` in the same cycle that `done` is high is accepted. The new result arrives with its own `done` seven edges later.
- R8: While `done` is high, every nibble of `bcdDigits` is in the range 0 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to capture `binIn` |
| binIn | input | 27 | Unsigned binary value to convert |
| bcdDigits | output | 32 | Eight decimal digits; units in bits [3:0] |
| overflow | output | 1 | Input was 100,000,000 or more |
| done | output | 1 | One-cycle pulse: digits and overflow valid |

## Verification
Two events can land in the same cycle. One is the done pulse that ends one conversion. The other is a start that opens the next conversion. The bench raises `start` with a fresh value in exactly the cycle where `done` is high. In that cycle it checks that the outputs still show the first result. Seven edges later it checks that the second value's digits appear, with a single new done pulse. A separate scenario pulses `start` in the middle of a conversion. The expected outcome is that the pulse changes neither the result nor the timing.

// File: rtl/bcd_pkg.sv
package bcd_pkg;

  typedef enum logic {ST_IDLE, ST_RUN} conv_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic step;
    logic finish;
  } conv_strobes_t;

  function automatic longint pow10(input int n);
    longint r;
    r = 1;
    for (int i = 0; i < n; i++) r = r * 10;
    return r;
  endfunction

endpackage

// File: rtl/bcd_conv_ctrl.sv
module bcd_conv_ctrl
  import bcd_pkg::*;
#(
  parameter int NUM_DIGITS = 8,
  localparam int POS_W = $clog2(NUM_DIGITS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  output conv_strobes_t    strobes,
  output logic [POS_W-1:0] pos,
  output logic             done
);

  conv_state_t state;

  always_comb begin
    strobes.load   = (state == ST_IDLE) && start;
    strobes.step   = (state == ST_RUN);
    strobes.finish = (state == ST_RUN) && (pos == POS_W'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      pos   <= '0;
      done  <= 1'b0;
    end else begin
      done <= strobes.finish;
      if (strobes.load) begin
        state <= ST_RUN;
        pos   <= POS_W'(NUM_DIGITS - 1);
      end else if (strobes.step) begin
        pos <= pos - POS_W'(1);
        if (strobes.finish) state <= ST_IDLE;
      end
    end
  end

endmodule

// File: rtl/bcd_digit_stage.sv
module bcd_digit_stage
  import bcd_pkg::*;
#(
  parameter int POS  = 1,
  parameter int IN_W = 27,
  localparam int RW  = $clog2(pow10(POS + 1))
) (
  input  logic [IN_W-1:0] remIn,
  output logic [3:0]      digit,
  output logic [IN_W-1:0] remOut
);

  logic          hiSet;
  logic [RW-1:0] lowRem;
  logic [RW-1:0] sub;

  assign lowRem = remIn[RW-1:0];

  generate
    if (RW < IN_W) begin : g_guard
      assign hiSet = |remIn[IN_W-1:RW];
    end else begin : g_noguard
      assign hiSet = 1'b0;
    end
  endgenerate

  // nine parallel compares; the largest fitting multiple wins
  always_comb begin
    digit = 4'd0;
    sub   = '0;
    for (int m = 1; m <= 9; m++) begin
      if (hiSet || (lowRem >= RW'(longint'(m) * pow10(POS)))) begin
        digit = 4'(m);
        sub   = RW'(longint'(m) * pow10(POS));
      end
    end
  end

  assign remOut = IN_W'(lowRem - sub);

endmodule

// File: rtl/bcd_conv_dpath.sv
module bcd_conv_dpath
  import bcd_pkg::*;
#(
  parameter int NUM_DIGITS = 8,
  localparam int IN_W  = $clog2(pow10(NUM_DIGITS)),
  localparam int POS_W = $clog2(NUM_DIGITS)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  conv_strobes_t           strobes,
  input  logic [POS_W-1:0]        pos,
  input  logic [IN_W-1:0]         binIn,
  output logic [NUM_DIGITS*4-1:0] digitsOut,
  output logic                    ovfOut
);

  logic [IN_W-1:0] remReg;
  logic [3:0]      digitReg [NUM_DIGITS];
  logic            ovfReg;

  logic [3:0]      stageDigit [NUM_DIGITS];
  logic [IN_W-1:0] stageRem   [NUM_DIGITS];
  logic [3:0]      selDigit;
  logic [IN_W-1:0] selRem;

  assign stageDigit[0] = 4'd0;
  assign stageRem[0]   = '0;

  generate
    for (genvar p = 1; p < NUM_DIGITS; p++) begin : g_stage
      bcd_digit_stage #(.POS(p), .IN_W(IN_W)) u_stage (
        .remIn  (remReg),
        .digit  (stageDigit[p]),
        .remOut (stageRem[p])
      );
    end
  endgenerate

  always_comb begin
    selDigit = 4'd0;
    selRem   = '0;
    for (int p = 1; p < NUM_DIGITS; p++) begin
      if (pos == POS_W'(p)) begin
        selDigit = stageDigit[p];
        selRem   = stageRem[p];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remReg <= '0;
      ovfReg <= 1'b0;
      for (int d = 0; d < NUM_DIGITS; d++) digitReg[d] <= 4'd0;
    end else if (strobes.load) begin
      remReg <= binIn;
      ovfReg <= (64'(binIn) >= 64'(pow10(NUM_DIGITS)));
      for (int d = 0; d < NUM_DIGITS; d++) digitReg[d] <= 4'd0;
    end else if (strobes.step) begin
      remReg <= selRem;
      for (int d = 1; d < NUM_DIGITS; d++) begin
        if (pos == POS_W'(d)) digitReg[d] <= selDigit;
      end
      if (strobes.finish) digitReg[0] <= selRem[3:0];
    end
  end

  always_comb begin
    for (int d = 0; d < NUM_DIGITS; d++) begin
      digitsOut[d*4 +: 4] = ovfReg ? 4'd9 : digitReg[d];
    end
  end

  assign ovfOut = ovfReg;

endmodule

// File: rtl/bcd_converter.sv
module bcd_converter
  import bcd_pkg::*;
#(
  parameter int NUM_DIGITS = 8,
  localparam int IN_W  = $clog2(pow10(NUM_DIGITS)),
  localparam int POS_W = $clog2(NUM_DIGITS)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic [IN_W-1:0]         binIn,
  output logic [NUM_DIGITS*4-1:0] bcdDigits,
  output logic                    overflow,
  output logic                    done
);

  conv_strobes_t    strobes;
  logic [POS_W-1:0] pos;

  bcd_conv_ctrl #(.NUM_DIGITS(NUM_DIGITS)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .strobes (strobes),
    .pos     (pos),
    .done    (done)
  );

  bcd_conv_dpath #(.NUM_DIGITS(NUM_DIGITS)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .pos       (pos),
    .binIn     (binIn),
    .digitsOut (bcdDigits),
    .ovfOut    (overflow)
  );

endmodule

// File: rtl/bcd_conv_chk.sv
module bcd_conv_chk #(
  parameter int NUM_DIGITS = 8,
  localparam int CNT_W = $clog2(NUM_DIGITS) + 1
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    start,
  input logic [NUM_DIGITS*4-1:0] digits,
  input logic                    overflow,
  input logic                    done
);

  // independent count of cycles left in the current conversion
  logic [CNT_W-1:0] left;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) left <= '0;
    else if (left == '0) left <= start ? CNT_W'(NUM_DIGITS - 1) : '0;
    else left <= left - CNT_W'(1);
  end

  function automatic bit allDecimal(input logic [NUM_DIGITS*4-1:0] v);
    bit ok;
    ok = 1'b1;
    for (int d = 0; d < NUM_DIGITS; d++) if (v[d*4 +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  // R2
  done_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (left == CNT_W'(1)) |=> done);

  // R2 R4
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (left != CNT_W'(1)) |=> !done);

  // R5
  ovf_nines_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && overflow) |-> (digits == {NUM_DIGITS{4'd9}}));

  // R8
  bcd_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> allDecimal(digits));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((left == '0) && !start) |=> ($stable(digits) && $stable(overflow)));

endmodule

bind bcd_converter bcd_conv_chk #(.NUM_DIGITS(NUM_DIGITS)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .digits   (bcdDigits),
  .overflow (overflow),
  .done     (done)
);

// File: tb/bcd_converter_bench.sv
module bcd_converter_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [26:0] binIn = '0;
  logic [31:0] bcdDigits;
  logic        overflow;
  logic        done;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  bcd_converter u_bcd_converter (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .binIn     (binIn),
    .bcdDigits (bcdDigits),
    .overflow  (overflow),
    .done      (done)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expDigits(input longint v);
    logic [31:0] r;
    longint p;
    if (v >= 100000000) return 32'h99999999;
    p = 1;
    for (int k = 0; k < 8; k++) begin
      r[k*4 +: 4] = 4'((v / p) % 10);
      p = p * 10;
    end
    return r;
  endfunction

  // starts at a negedge; returns at the negedge where done should be high
  task automatic runConv(input longint v, input string req);
    bit early;
    early = 1'b0;
    @(negedge clk);
    binIn = 27'(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    binIn = 27'($urandom);
    for (int i = 1; i < 8; i++) begin
      if (done) early = 1'b1;
      @(negedge clk);
    end
    check(!early, "R2 early done", 1, 0);
    check(done === 1'b1, "R2 done", done, 1);
    check(bcdDigits === expDigits(v), req, bcdDigits, expDigits(v));
    check(overflow === (v >= 100000000), "R5 overflow flag", overflow, (v >= 100000000));
    for (int d = 0; d < 8; d++)
      check(bcdDigits[d*4 +: 4] <= 4'd9, "R8 nibble range", bcdDigits[d*4 +: 4], 9);
  endtask

  task automatic testReset();
    check(bcdDigits === 32'h0, "R1 digits", bcdDigits, 0);
    check(overflow === 1'b0, "R1 overflow", overflow, 0);
    check(done === 1'b0, "R1 done", done, 0);
  endtask

  task automatic testBoundaries();
    longint p;
    runConv(0, "R3 zero");
    runConv(99999999, "R3 max in range");
    p = 1;
    for (int k = 0; k < 8; k++) begin
      runConv(p, "R3 power of ten");
      runConv(p - 1, "R3 power of ten minus one");
      p = p * 10;
    end
  endtask

  task automatic testOverflow();
    runConv(100000000, "R5 first overflow value");
    runConv(134217727, "R5 largest input");
    runConv(12345678, "R5 clears after overflow");
  endtask

  task automatic testRandom();
    for (int i = 0; i < 40; i++) runConv(longint'($urandom % 100000000), "R3 random");
  endtask

  task automatic testHold();
    logic [31:0] held;
    runConv(87654321, "R6 setup");
    held = bcdDigits;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      binIn = 27'($urandom);
      check(bcdDigits === held, "R6 digits hold", bcdDigits, held);
      check(overflow === 1'b0, "R6 overflow hold", overflow, 0);
      check(done === 1'b0, "R6 single done", done, 0);
    end
  endtask

  task automatic testBusyStart();
    bit extra;
    extra = 1'b0;
    @(negedge clk);
    binIn = 27'(24681357);
    start = 1'b1;
    @(negedge clk);                  // n1
    start = 1'b0;
    @(negedge clk);                  // n2
    @(negedge clk);                  // n3
    binIn = 27'(11111111);
    start = 1'b1;
    @(negedge clk);                  // n4
    start = 1'b0;
    repeat (4) @(negedge clk);       // n8
    check(done === 1'b1, "R4 done timing", done, 1);
    check(bcdDigits === expDigits(24681357), "R4 first value kept", bcdDigits, expDigits(24681357));
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (done) extra = 1'b1;
    end
    check(!extra, "R4 no extra done", extra, 0);
    check(bcdDigits === expDigits(24681357), "R4 result unchanged", bcdDigits, expDigits(24681357));
  endtask

  task automatic testBackToBack();
    bit early;
    early = 1'b0;
    runConv(13579246, "R7 first");
    binIn = 27'(50607080);
    start = 1'b1;
    #1;
    check(bcdDigits === expDigits(13579246), "R7 old result during done", bcdDigits, expDigits(13579246));
    @(negedge clk);
    start = 1'b0;
    for (int i = 1; i < 8; i++) begin
      if (done) early = 1'b1;
      @(negedge clk);
    end
    check(!early, "R7 no early done", 1, 0);
    check(done === 1'b1, "R7 second done", done, 1);
    check(bcdDigits === expDigits(50607080), "R7 second result", bcdDigits, expDigits(50607080));
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBoundaries();
    testOverflow();
    testRandom();
    testHold();
    testBusyStart();
    testBackToBack();
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule